// File: doc/BRIEF.md
# UART Transmit Channel with Break Control

This block is the transmit half of one asynchronous serial channel. Bytes enter through a valid/ready stream port and are stored in a four-entry queue. A line engine turns each byte into a serial frame on `txd`. A separate command decoder sends one-cycle strobes that enable or disable the transmitter, start or stop a break, or clear the channel back to its power-on state. Bit timing comes from a `bit_tick` input. Each pulse of `bit_tick` advances the line by one bit, so the baud generator stays outside the block.

A break is ordered behind traffic. A start-break request waits until the frame in flight and every queued byte have gone out, and only then holds the line low. A stop-break request drives the line high again and keeps it high for at least one full bit before the next frame starts. Disabling the transmitter blocks further loads and drops both status flags at once. Bytes already accepted are still sent, after which the channel goes idle.

Stream rule: a byte moves on every rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the transmitter is disabled or the queue is full. A source that is held off may keep `in_valid` asserted. No byte is taken while `in_ready` is low, and such a byte is never sent later.

Top module: `serial_tx_chan`

## Requirements
- R1: After `rst_n` is released, `txd` is 1 and `tx_rdy`, `tx_emt` and `in_ready` are 0, because the transmitter starts out disabled.
- R2: While the transmitter is disabled, `in_ready` is 0. A byte offered with `in_valid` during that time is never transmitted.
- R3: A frame is one start bit (0), then eight data bits with bit 0 first, then one stop bit (1). Each bit lasts exactly one `bit_tick` period. `txd` changes only in the cycle after a `bit_tick`. When the queue holds more data at the end of a stop bit, the next start bit follows with no idle bit.
- R4: The queue holds four bytes. With four bytes held, `in_ready` and `tx_rdy` are 0 and further offers are not taken. Bytes leave in the order they arrived.
- R5: `tx_rdy` is 1 exactly when the transmitter is enabled and the queue has space. `tx_emt` is 1 exactly when the transmitter is enabled, the queue is empty and no frame is being shifted.
- R6: An enable strobe on an idle, empty channel makes `tx_rdy` and `tx_emt` 1 in the next cycle.
- R7: A disable strobe makes `tx_rdy`, `tx_emt` and `in_ready` 0 in the next cycle. Bytes already in the queue or the shifter are still sent in full, and the line then idles high.
- R8: A start-break strobe on an enabled, empty channel drives `txd` low by the second following `bit_tick` at the latest. `txd` stays low until a stop-break is taken.
- R9: A start-break strobe given while a frame is in flight or bytes are queued first lets every such byte be sent. The line goes low at the first `bit_tick` after the last stop bit. No byte is taken from the queue while the line is in break.
- R10: A start-break strobe while the transmitter is disabled is ignored. It is not remembered for a later enable.
- R11: After a stop-break strobe, `txd` is 1 by the second following `bit_tick` at the latest. It stays 1 for at least one full bit before any following start bit.
- R12: A clear strobe (`tx_clear`) empties the queue, cancels any pending or active break, disables the transmitter and drives `txd` to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_clear | input | 1 | Strobe: return the channel to its reset state |
| cmd_tx_on | input | 1 | Strobe: enable the transmitter |
| cmd_tx_off | input | 1 | Strobe: disable the transmitter (wins over enable in the same cycle) |
| cmd_brk_on | input | 1 | Strobe: request a break |
| cmd_brk_off | input | 1 | Strobe: end or cancel a break |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| in_valid | input | 1 | Stream: byte offered |
| in_data | input | DATA_W | Stream: byte value |
| in_ready | output | 1 | Stream: byte can be taken this cycle |
| txd | output | 1 | Serial line, idles high |
| tx_rdy | output | 1 | Enabled and queue has space |
| tx_emt | output | 1 | Enabled, queue empty and shifter idle |

## Verification
The bench records the line value after every bit tick and decodes all 256 byte values from that record. A wrong bit order, a lost stop bit or an idle gap between queued frames would show up as a mismatched byte or an extra high bit. It queues bytes ahead of a break request and checks that the low level starts right after the last stop bit. A design that broke into a frame, or dropped the queued bytes, would show a short frame or a missing byte. It also checks that a stop-break leaves at least one high bit before the next start bit, and that a break request made while disabled is not replayed after a later enable. It checks that a clear strobe empties the queue and cancels a pending break, so that nothing leaves the line after re-enabling.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef enum logic [1:0] {
    LN_IDLE  = 2'd0,
    LN_FRAME = 2'd1,
    LN_BREAK = 2'd2,
    LN_MARK  = 2'd3
  } line_state_e;
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/tx_line_engine.sv
module tx_line_engine
  import serial_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         tick,
  input  logic         have_data,
  input  logic [W-1:0] head,
  output logic         take,
  input  logic         brk_go,
  input  logic         brk_end,
  output logic         txd,
  output logic         busy,
  output logic         in_break
);
  localparam int FRAME_BITS = W + 2;
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  line_state_e   st;
  logic [W:0]    shreg;
  logic [CW-1:0] cnt;
  logic          brk_pend, stop_pend;
  logic          frame_end, decide, brk_now;

  assign frame_end = (st == LN_FRAME) && (cnt == LAST);
  assign decide    = tick && ((st == LN_IDLE) || (st == LN_MARK) || frame_end);
  assign take      = decide && have_data;
  assign brk_now   = brk_pend && !brk_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LN_IDLE;
      shreg     <= '1;
      cnt       <= '0;
      txd       <= 1'b1;
      brk_pend  <= 1'b0;
      stop_pend <= 1'b0;
    end else if (flush) begin
      st        <= LN_IDLE;
      shreg     <= '1;
      cnt       <= '0;
      txd       <= 1'b1;
      brk_pend  <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      if (brk_go && st != LN_BREAK) brk_pend <= 1'b1;
      if (brk_end) brk_pend <= 1'b0;
      if (brk_end && st == LN_BREAK) stop_pend <= 1'b1;
      if (decide) begin
        if (have_data) begin
          st    <= LN_FRAME;
          txd   <= 1'b0;
          shreg <= {1'b1, head};
          cnt   <= '0;
        end else if (brk_now) begin
          st       <= LN_BREAK;
          txd      <= 1'b0;
          brk_pend <= 1'b0;
        end else begin
          st  <= LN_IDLE;
          txd <= 1'b1;
        end
      end else if (tick && st == LN_FRAME) begin
        txd   <= shreg[0];
        shreg <= {1'b1, shreg[W:1]};
        cnt   <= cnt + 1'b1;
      end else if (tick && st == LN_BREAK && stop_pend) begin
        st        <= LN_MARK;
        txd       <= 1'b1;
        stop_pend <= 1'b0;
      end
    end
  end

  assign busy     = (st == LN_FRAME);
  assign in_break = (st == LN_BREAK);
endmodule

// File: rtl/serial_tx_chan.sv
module serial_tx_chan #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_clear,
  input  logic              cmd_tx_on,
  input  logic              cmd_tx_off,
  input  logic              cmd_brk_on,
  input  logic              cmd_brk_off,
  input  logic              bit_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic              tx_rdy,
  output logic              tx_emt
);
  logic              tx_en;
  logic              fifo_full, fifo_empty, fifo_pop, fifo_push;
  logic [DATA_W-1:0] fifo_head;
  logic              line_busy, line_brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_en <= 1'b0;
    else if (tx_clear)   tx_en <= 1'b0;
    else if (cmd_tx_off) tx_en <= 1'b0;
    else if (cmd_tx_on)  tx_en <= 1'b1;
  end

  assign in_ready  = tx_en && !fifo_full;
  assign fifo_push = in_valid && in_ready;

  tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_clear),
    .push  (fifo_push),
    .wdata (in_data),
    .pop   (fifo_pop),
    .rdata (fifo_head),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  tx_line_engine #(.W(DATA_W)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_clear),
    .tick      (bit_tick),
    .have_data (!fifo_empty),
    .head      (fifo_head),
    .take      (fifo_pop),
    .brk_go    (cmd_brk_on && tx_en),
    .brk_end   (cmd_brk_off),
    .txd       (txd),
    .busy      (line_busy),
    .in_break  (line_brk)
  );

  assign tx_rdy = tx_en && !fifo_full;
  assign tx_emt = tx_en && fifo_empty && !line_busy;
endmodule

// File: rtl/serial_tx_chan_chk.sv
module serial_tx_chan_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_clear,
  input logic cmd_tx_off,
  input logic bit_tick,
  input logic in_ready,
  input logic txd,
  input logic tx_rdy,
  input logic tx_emt,
  input logic fifo_full,
  input logic fifo_pop,
  input logic line_brk
);
  // R12
  clear_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clear |=> (txd && !tx_rdy && !tx_emt && !in_ready));

  // R7
  disable_drops_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_off |=> (!tx_rdy && !tx_emt && !in_ready));

  // R4
  full_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !in_ready);

  // R5
  emt_implies_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_emt |-> tx_rdy);

  // R3
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !tx_clear) |=> $stable(txd));

  // R9
  no_pop_in_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_brk |-> !fifo_pop);
endmodule

bind serial_tx_chan serial_tx_chan_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_clear   (tx_clear),
  .cmd_tx_off (cmd_tx_off),
  .bit_tick   (bit_tick),
  .in_ready   (in_ready),
  .txd        (txd),
  .tx_rdy     (tx_rdy),
  .tx_emt     (tx_emt),
  .fifo_full  (fifo_full),
  .fifo_pop   (fifo_pop),
  .line_brk   (line_brk)
);

// File: tb/sim_serial_tx_chan.sv
module sim_serial_tx_chan;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 4;
  localparam int MAXBITS    = 8192;

  logic clk, rst_n, tx_clear, cmd_tx_on, cmd_tx_off, cmd_brk_on, cmd_brk_off;
  logic bit_tick, in_valid, in_ready, txd, tx_rdy, tx_emt;
  logic [7:0] in_data;

  int checks = 0;
  int errors = 0;
  bit stream [MAXBITS];
  int wr = 0;
  bit tick_en = 0;

  serial_tx_chan u0 (
    .clk(clk), .rst_n(rst_n), .tx_clear(tx_clear), .cmd_tx_on(cmd_tx_on),
    .cmd_tx_off(cmd_tx_off), .cmd_brk_on(cmd_brk_on), .cmd_brk_off(cmd_brk_off),
    .bit_tick(bit_tick), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // bit tick generator; records the line value right after each tick
  initial begin
    bit_tick = 1'b0;
    forever begin
      @(negedge clk);
      if (tick_en) begin
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        if (wr < MAXBITS) begin
          stream[wr] = txd;
          wr++;
        end
        repeat (BIT_CYC - 2) @(negedge clk);
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input int k);
    @(negedge clk);
    case (k)
      0: cmd_tx_on = 1'b1;
      1: cmd_tx_off = 1'b1;
      2: cmd_brk_on = 1'b1;
      3: cmd_brk_off = 1'b1;
      default: tx_clear = 1'b1;
    endcase
    @(negedge clk);
    cmd_tx_on = 1'b0; cmd_tx_off = 1'b0; cmd_brk_on = 1'b0;
    cmd_brk_off = 1'b0; tx_clear = 1'b0;
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BIT_CYC) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    logic r;
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      r = in_ready;
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_empty();
    while (!tx_emt) @(negedge clk);
    wait_bits(2);
  endtask

  function automatic int zeros(input int a, input int b);
    int z = 0;
    for (int i = a; i < b && i < wr; i++) if (!stream[i]) z++;
    return z;
  endfunction

  task automatic frame_at(input int from, output int nxt, output logic [7:0] v,
                          output bit ok, output int lead);
    int p;
    p = from; lead = 0; ok = 0; v = '0;
    while (p < wr && stream[p]) begin p++; lead++; end
    nxt = p;
    if (p + 10 <= wr && !stream[p]) begin
      for (int i = 0; i < 8; i++) v[i] = stream[p + 1 + i];
      ok  = stream[p + 9];
      nxt = p + 10;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int mark, p, lead, bad_v, bad_gap;
    logic [7:0] v;
    bit ok;
    rst_n = 1'b0; tx_clear = 1'b0; cmd_tx_on = 1'b0; cmd_tx_off = 1'b0;
    cmd_brk_on = 1'b0; cmd_brk_off = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "txd", txd, 1);
    chk("R1", "tx_rdy", tx_rdy, 0);
    chk("R1", "tx_emt", tx_emt, 0);
    chk("R1", "in_ready", in_ready, 0);

    // R2 loads refused while disabled
    tick_en = 1;
    in_valid = 1'b1; in_data = 8'h55;
    repeat (8) @(negedge clk);
    chk("R2", "in_ready while disabled", in_ready, 0);
    in_valid = 1'b0;
    cmd(0);
    // R6 enable on idle channel
    chk("R6", "tx_rdy after enable", tx_rdy, 1);
    chk("R6", "tx_emt after enable", tx_emt, 1);
    #1 mark = wr;
    wait_bits(15);
    chk("R2", "zeros on line after refused load", zeros(mark, wr), 0);

    // R3 sweep of all byte values, back to back
    #1 mark = wr;
    for (int i = 0; i < 256; i++) begin
      push(8'(i));
      if (i == 8) chk("R5", "tx_emt while sending", tx_emt, 0);
    end
    wait_empty();
    p = mark; bad_v = 0; bad_gap = 0;
    for (int i = 0; i < 256; i++) begin
      frame_at(p, p, v, ok, lead);
      if (!ok || v != 8'(i)) bad_v++;
      if (i > 0 && lead != 0) bad_gap++;
    end
    chk("R3", "mismatched frames in sweep", bad_v, 0);
    chk("R3", "idle gaps between queued frames", bad_gap, 0);

    // R4 queue depth and order
    tick_en = 0;
    wait_bits(2);
    push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
    chk("R4", "in_ready when full", in_ready, 0);
    chk("R5", "tx_rdy when full", tx_rdy, 0);
    chk("R5", "tx_emt when queued", tx_emt, 0);
    in_valid = 1'b1; in_data = 8'hEE;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    mark = wr;
    tick_en = 1;
    wait_empty();
    p = mark; bad_v = 0;
    for (int i = 0; i < 4; i++) begin
      frame_at(p, p, v, ok, lead);
      if (!ok || v != 8'hA1 + 8'(i)) bad_v++;
    end
    chk("R4", "queued frames in order", bad_v, 0);
    chk("R4", "no fifth byte sent", zeros(p, wr), 0);

    // R7 disable drains the queue
    tick_en = 0;
    wait_bits(2);
    push(8'hB0); push(8'hB1); push(8'hB2);
    cmd(1);
    chk("R7", "tx_rdy after disable", tx_rdy, 0);
    chk("R7", "tx_emt after disable", tx_emt, 0);
    chk("R7", "in_ready after disable", in_ready, 0);
    mark = wr;
    tick_en = 1;
    wait_bits(40);
    p = mark; bad_v = 0;
    for (int i = 0; i < 3; i++) begin
      frame_at(p, p, v, ok, lead);
      if (!ok || v != 8'hB0 + 8'(i)) bad_v++;
    end
    chk("R7", "drained frames", bad_v, 0);
    chk("R7", "line idle after drain", zeros(p, wr), 0);
    chk("R7", "tx_emt stays low while disabled", tx_emt, 0);
    cmd(0);
    chk("R6", "tx_emt after re-enable", tx_emt, 1);

    // R8 break from an empty channel
    wait_bits(2);
    cmd(2);
    #1 mark = wr;
    wait_bits(12);
    chk("R8", "low within two bits", (!stream[mark] || !stream[mark+1]) ? 1 : 0, 1);
    chk("R8", "high bits during break", 10 - zeros(mark + 2, mark + 12), 0);

    // R11 stop break, then a frame after one high bit
    cmd(3);
    #1 mark = wr;
    push(8'h3C);
    wait_empty();
    chk("R11", "high within two bits", (stream[mark] || stream[mark+1]) ? 1 : 0, 1);
    p = mark;
    if (!stream[p]) p++;
    frame_at(p, p, v, ok, lead);
    chk("R11", "high bits before start", (lead >= 1) ? 1 : 0, 1);
    chk("R11", "frame after break", {ok, v}, {1'b1, 8'h3C});

    // R9 break waits for queued bytes
    tick_en = 0;
    wait_bits(2);
    push(8'hC0); push(8'hC1);
    cmd(2);
    mark = wr;
    tick_en = 1;
    wait_bits(32);
    p = mark; bad_v = 0;
    for (int i = 0; i < 2; i++) begin
      frame_at(p, p, v, ok, lead);
      if (!ok || v != 8'hC0 + 8'(i)) bad_v++;
    end
    chk("R9", "queued frames before break", bad_v, 0);
    chk("R9", "low right after last stop bit", zeros(p, p + 9), 9);
    cmd(3);
    wait_bits(4);
    chk("R11", "txd high after stop", txd, 1);

    // R10 break ignored while disabled
    cmd(1);
    wait_bits(2);
    #1 mark = wr;
    cmd(2);
    wait_bits(8);
    chk("R10", "zeros after break while disabled", zeros(mark, wr), 0);
    cmd(0);
    #1 mark = wr;
    wait_bits(6);
    chk("R10", "no replay after enable", zeros(mark, wr), 0);

    // R12 clear flushes queue and pending break
    tick_en = 0;
    wait_bits(2);
    push(8'hD0); push(8'hD1);
    cmd(2);
    cmd(4);
    chk("R12", "txd after clear", txd, 1);
    chk("R12", "tx_rdy after clear", tx_rdy, 0);
    chk("R12", "tx_emt after clear", tx_emt, 0);
    chk("R12", "in_ready after clear", in_ready, 0);
    cmd(0);
    mark = wr;
    tick_en = 1;
    wait_bits(30);
    chk("R12", "nothing sent after clear", zeros(mark, wr), 0);
    cmd(2);
    wait_bits(3);
    chk("R8", "txd low in break", txd, 0);
    cmd(4);
    chk("R12", "clear ends active break", txd, 1);

    summary();
    $finish;
  end
endmodule